// File: doc/BRIEF.md
# Read Strobe Postamble Gate

This block produces the enable that gates a bidirectional read strobe before the strobe clocks the read-data capture registers. A memory device drives the strobe low for a short time before it starts toggling and again after its last falling edge, before it lets the line float. Noise or ringing on the floating line after a burst must not reach the capture flops, so the strobe is passed on only while a registered enable is high.

The controller asks for the read window through `rd_en_req`. With `MODE` set to full rate, bit 0 is sampled on every rising edge of the full-rate clock. With `MODE` set to half rate, a word of `SLOTS` enable bits is first captured on the rising edge of the half-rate resynchronization clock, then fed out one bit per full-rate cycle, earliest slot first. In both modes the selected bit becomes a staged enable on a full-rate rising edge. A postamble register copies the staged enable on the following falling edge, and the output enable is the AND of the staged enable and that register. As a result, the enable comes up half a cycle after the staged enable rises and goes down on the same edge at which the staged enable falls.

Top module: `rd_strobe_gate`

## Requirements
- R1: While `rst_n` is low, `strobe_en` and `strobe_gated` are low. The staged enable is low at the first `clk_full` rising edge after reset release.
- R2: `strobe_gated` equals `strobe_raw` AND `strobe_en` at every instant, and is therefore low whenever `strobe_en` is low.
- R3: In full-rate mode, the staged enable is `rd_en_req[0]` as sampled at each `clk_full` rising edge. When it rises at edge k, `strobe_en` rises at the `clk_full` falling edge after edge k. `strobe_en` then stays high without a gap for as long as the staged enable stays high.
- R4: When the staged enable is sampled low at a `clk_full` rising edge, `strobe_en` is low from that same edge onward, with no added delay.
- R5: In full-rate mode, `rd_en_req[SLOTS-1:1]` has no effect on either output.
- R6: In half-rate mode, `rd_en_req` is captured at each `clk_half` rising edge. Bit 0 of the captured word becomes the staged enable at the next `clk_full` rising edge and bit 1 at the edge after that. `clk_half` rises on every second `clk_full` rising edge, and the first `clk_full` rising edge after reset release must coincide with a `clk_half` rising edge. At that first edge the staged enable is low.
- R7: After the staged enable has been low for at least one cycle, `strobe_en` stays low for the first half cycle after the staged enable returns high.
- R8: While the staged enable is low, toggling on `strobe_raw` causes no edge on `strobe_gated`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_full | input | 1 | Full-rate clock; staging on the rising edge, postamble register on the falling edge |
| clk_half | input | 1 | Half-rate resynchronization clock from a divider; used in half-rate mode |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| rd_en_req | input | SLOTS | Read-window request: one slot per full-rate cycle (half rate) or bit 0 only (full rate) |
| strobe_raw | input | 1 | Delayed read strobe from the pad |
| strobe_gated | output | 1 | Strobe passed to the capture registers; low outside the enable window |
| strobe_en | output | 1 | Registered postamble enable |

## Verification
The bench drives one staged-enable sequence into a full-rate instance and a half-rate instance together, so both must produce the same enable. A difference between the two shows an error in slot order or in reset alignment. The sequence starts with bursts of one to five cycles separated by gaps of one to three cycles. Single-cycle bursts show whether assertion takes half a cycle or a whole cycle. One-cycle gaps show whether the AND after the postamble register drops the enable at once and holds it off through the restart half cycle. A long run and a pseudo-random tail then check that the enable does not dip between back-to-back cycles. The raw strobe toggles on a period that is not locked to either clock, which produces glitches inside the postamble windows, where any edge on the gated strobe is counted.

// File: rtl/rsg_pkg.sv
package rsg_pkg;

  // Which request path feeds the staged enable.
  typedef enum logic {
    RSG_MODE_FULL = 1'b0,
    RSG_MODE_HALF = 1'b1
  } rsg_mode_e;

  // Enable slots carried by one half-rate request word.
  localparam int unsigned RSG_DEFAULT_SLOTS = 2;

  // Width of a slot index; never less than one bit.
  function automatic int unsigned rsg_idx_w(input int unsigned slots);
    return (slots > 1) ? $clog2(slots) : 1;
  endfunction

endpackage

// File: rtl/rsg_hdr_capture.sv
// First capture stage on the half-rate resynchronization clock.
module rsg_hdr_capture #(
  parameter int unsigned WIDTH = 2
) (
  input  logic             clk_half,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] word_in,
  output logic [WIDTH-1:0] word_q
);

  logic [WIDTH-1:0] word_d;

  always_comb begin
    word_d = word_in;
  end

  always_ff @(posedge clk_half or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
    end else begin
      word_q <= word_d;
    end
  end

endmodule

// File: rtl/rsg_serializer.sv
// Feeds out one slot of the captured word per full-rate cycle, slot 0 first.
// The phase resets to the last slot, so the first full-rate edge after reset
// (a half-rate rising edge) still reads the previous (reset) word.
module rsg_serializer #(
  parameter int unsigned SLOTS = 2
) (
  input  logic             clk_full,
  input  logic             rst_n,
  input  logic [SLOTS-1:0] word_q,
  output logic             en_src
);

  localparam int unsigned    IDX_W = rsg_pkg::rsg_idx_w(SLOTS);
  localparam logic [IDX_W-1:0] LAST_SLOT = IDX_W'(SLOTS - 1);

  logic [IDX_W-1:0] ph_q;
  logic [IDX_W-1:0] ph_d;
  logic             en_d;

  always_comb begin
    ph_d = (ph_q == LAST_SLOT) ? '0 : (ph_q + IDX_W'(1));
    en_d = word_q[ph_q];
  end

  always_ff @(posedge clk_full or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= LAST_SLOT;
      en_src <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      en_src <= en_d;
    end
  end

endmodule

// File: rtl/rsg_fr_stage.sv
// Full-rate request path: one staging flop on the full-rate rising edge.
module rsg_fr_stage (
  input  logic clk_full,
  input  logic rst_n,
  input  logic req_bit,
  output logic en_src
);

  logic en_d;

  always_comb begin
    en_d = req_bit;
  end

  always_ff @(posedge clk_full or negedge rst_n) begin
    if (!rst_n) begin
      en_src <= 1'b0;
    end else begin
      en_src <= en_d;
    end
  end

endmodule

// File: rtl/rsg_postamble.sv
// Falling-edge postamble register and the AND that follows it.
// Rise: waits for the falling edge (half cycle). Fall: follows en_src at once.
module rsg_postamble (
  input  logic clk_full,
  input  logic rst_n,
  input  logic en_src,
  output logic en_gate
);

  logic pst_q;
  logic pst_d;

  always_comb begin
    pst_d = en_src;
  end

  always_ff @(negedge clk_full or negedge rst_n) begin
    if (!rst_n) begin
      pst_q <= 1'b0;
    end else begin
      pst_q <= pst_d;
    end
  end

  always_comb begin
    en_gate = en_src & pst_q;
  end

endmodule

// File: rtl/rd_strobe_gate.sv
module rd_strobe_gate
  import rsg_pkg::*;
#(
  parameter rsg_mode_e   MODE  = RSG_MODE_HALF,
  parameter int unsigned SLOTS = RSG_DEFAULT_SLOTS
) (
  input  logic             clk_full,
  input  logic             clk_half,
  input  logic             rst_n,
  input  logic [SLOTS-1:0] rd_en_req,
  input  logic             strobe_raw,
  output logic             strobe_gated,
  output logic             strobe_en
);

  logic en_src;
  logic en_gate;

  generate
    if (MODE == RSG_MODE_HALF) begin : g_half
      logic [SLOTS-1:0] word_q;

      rsg_hdr_capture #(
        .WIDTH (SLOTS)
      ) u_hdr (
        .clk_half (clk_half),
        .rst_n    (rst_n),
        .word_in  (rd_en_req),
        .word_q   (word_q)
      );

      rsg_serializer #(
        .SLOTS (SLOTS)
      ) u_ser (
        .clk_full (clk_full),
        .rst_n    (rst_n),
        .word_q   (word_q),
        .en_src   (en_src)
      );
    end else begin : g_full
      logic unused_inputs;

      always_comb begin
        unused_inputs = clk_half ^ (^rd_en_req);
      end

      rsg_fr_stage u_fr (
        .clk_full (clk_full),
        .rst_n    (rst_n),
        .req_bit  (rd_en_req[0]),
        .en_src   (en_src)
      );
    end
  endgenerate

  rsg_postamble u_pst (
    .clk_full (clk_full),
    .rst_n    (rst_n),
    .en_src   (en_src),
    .en_gate  (en_gate)
  );

  always_comb begin
    strobe_en    = en_gate;
    strobe_gated = strobe_raw & en_gate;
  end

endmodule

// File: rtl/rsg_checker.sv
module rsg_checker
  import rsg_pkg::*;
#(
  parameter rsg_mode_e   MODE  = RSG_MODE_HALF,
  parameter int unsigned SLOTS = RSG_DEFAULT_SLOTS
) (
  input logic             clk_full,
  input logic             clk_half,
  input logic             rst_n,
  input logic [SLOTS-1:0] rd_en_req,
  input logic             strobe_raw,
  input logic             strobe_gated,
  input logic             strobe_en
);

  // R1: outputs held low during reset
  a_r1_reset_quiet: assert property (@(posedge clk_full)
    !rst_n |-> (!strobe_en && !strobe_gated));

  // R2: gated strobe is low whenever the enable is low
  a_r2_gate_low: assert property (@(posedge clk_full) disable iff (!rst_n)
    !strobe_en |-> !strobe_gated);

  // R2: gated strobe follows a high raw strobe inside the window
  a_r2_gate_pass: assert property (@(negedge clk_full) disable iff (!rst_n)
    (strobe_en && strobe_raw) |-> strobe_gated);

  generate
    if (MODE == RSG_MODE_FULL) begin : g_full_chk
      // R3: a sampled request is visible as enable before the next rising edge
      a_r3_rise_half_cycle: assert property (@(posedge clk_full) disable iff (!rst_n)
        rd_en_req[0] |=> strobe_en);

      // R4: a low request removes the enable for the whole following cycle
      a_r4_drop_no_delay: assert property (@(posedge clk_full) disable iff (!rst_n)
        !rd_en_req[0] |=> !strobe_en);
    end else begin : g_half_chk
      // R6: an all-low word keeps the enable low through its first slot
      a_r6_word_low: assert property (@(posedge clk_half) disable iff (!rst_n)
        (rd_en_req == '0) |=> !strobe_en);

      // R6: an all-high word brings the enable up within its first slot
      a_r6_word_high: assert property (@(posedge clk_half) disable iff (!rst_n)
        (&rd_en_req) |=> strobe_en);
    end
  endgenerate

endmodule

bind rd_strobe_gate rsg_checker #(
  .MODE  (MODE),
  .SLOTS (SLOTS)
) u_rsg_checker (
  .clk_full     (clk_full),
  .clk_half     (clk_half),
  .rst_n        (rst_n),
  .rd_en_req    (rd_en_req),
  .strobe_raw   (strobe_raw),
  .strobe_gated (strobe_gated),
  .strobe_en    (strobe_en)
);

// File: tb/rd_strobe_gate_bench.sv
module rd_strobe_gate_bench;
  import rsg_pkg::*;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int N         = 170;
  localparam int WD_CYCLES = 20000;

  logic       clk_full;
  logic       clk_half;
  logic       rst_n;
  logic       strobe_raw;
  logic [1:0] req_h;
  logic [1:0] req_f;
  logic       gated_h, en_h;
  logic       gated_f, en_f;

  int  n_cmp;
  int  n_bad;
  int  n_glitch;
  bit  quiet;
  bit  s_seq [0:N+1];
  bit  exp_q [$];
  string lbl_q [$];

  rd_strobe_gate #(.MODE(RSG_MODE_HALF), .SLOTS(2)) u_rd_strobe_gate (
    .clk_full(clk_full), .clk_half(clk_half), .rst_n(rst_n), .rd_en_req(req_h),
    .strobe_raw(strobe_raw), .strobe_gated(gated_h), .strobe_en(en_h));

  rd_strobe_gate #(.MODE(RSG_MODE_FULL), .SLOTS(2)) u_rd_strobe_gate_fr (
    .clk_full(clk_full), .clk_half(clk_half), .rst_n(rst_n), .rd_en_req(req_f),
    .strobe_raw(strobe_raw), .strobe_gated(gated_f), .strobe_en(en_f));

  // 125 MHz full-rate clock; half-rate clock divided from it
  initial clk_full = 1'b0;
  always #4 clk_full = ~clk_full;

  initial clk_half = 1'b0;
  always @(posedge clk_full) clk_half <= ~clk_half;

  // Free-running raw strobe, never toggling on a clock edge or a sample point
  initial begin
    strobe_raw = 1'b0;
    #0.75;
    forever #1.5 strobe_raw = ~strobe_raw;
  end

  // R8: any edge on a gated strobe inside a postamble window is a glitch
  always @(gated_f or gated_h) begin
    if (quiet) n_glitch++;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic build_seq();
    int idx;
    logic [7:0] lf;
    idx = 1;
    s_seq[0] = 1'b0;               // R6: staged enable low at first edge
    for (int l = 1; l <= 5; l++) begin
      for (int g = 1; g <= 3; g++) begin
        for (int i = 0; i < l; i++) begin s_seq[idx] = 1'b1; idx++; end
        for (int i = 0; i < g; i++) begin s_seq[idx] = 1'b0; idx++; end
      end
    end
    for (int i = 0; i < 10; i++) begin s_seq[idx] = 1'b1; idx++; end
    for (int i = 0; i < 3; i++)  begin s_seq[idx] = 1'b0; idx++; end
    lf = 8'hA5;
    while (idx < N - 4) begin
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      s_seq[idx] = lf[0];
      idx++;
    end
    while (idx <= N + 1) begin s_seq[idx] = 1'b0; idx++; end
  endtask

  // Driver: sets requests at the falling edge before rising edge k and pushes
  // the expected enable for both halves of cycle k.
  task automatic drive_all();
    for (int k = 0; k < N; k++) begin
      bit    prev;
      bit    junk;
      string l1;
      string l2;
      prev = (k == 0) ? 1'b0 : s_seq[k-1];
      junk = k[0] ^ k[2];
      req_f = {junk, s_seq[k]};                       // R5: upper bit is noise
      if (k % 2 == 0) req_h = {s_seq[k+2], s_seq[k+1]}; // R6: slot 0 earlier
      if (s_seq[k] && !prev)      l1 = "R7 restart first half";
      else if (!s_seq[k] && prev) l1 = "R4 drop at edge";
      else                        l1 = "R3 steady first half";
      if (s_seq[k] && !prev)      l2 = "R3 rise after half cycle";
      else if (s_seq[k])          l2 = "R3 steady second half";
      else                        l2 = "R4 idle second half";
      if (junk) begin
        l1 = {l1, " R5 upper bit set"};
        l2 = {l2, " R5 upper bit set"};
      end
      exp_q.push_back(s_seq[k] & prev); lbl_q.push_back(l1);
      exp_q.push_back(s_seq[k]);        lbl_q.push_back(l2);
      @(negedge clk_full);
    end
  endtask

  task automatic compare_one();
    bit    e;
    string l;
    logic  raw;
    if (exp_q.size() == 0) begin
      chk("scoreboard underrun R3", 32'd0, 32'd1);
      return;
    end
    e   = exp_q.pop_front();
    l   = lbl_q.pop_front();
    raw = strobe_raw;
    chk(l, en_f, e);
    chk({"R6 ", l}, en_h, e);
    chk("R2 full-rate gated", gated_f, raw & e);
    chk("R2 half-rate gated", gated_h, raw & e);
  endtask

  // Monitor: samples 2 ns after each edge and compares against the queue
  task automatic monitor_all();
    for (int k = 0; k < N; k++) begin
      @(posedge clk_full);
      #2 compare_one();
      #1 quiet = !s_seq[k];
      @(negedge clk_full);
      #2 compare_one();
    end
    quiet = 1'b0;
  endtask

  initial begin
    n_cmp = 0; n_bad = 0; n_glitch = 0; quiet = 1'b0;
    rst_n = 1'b0;
    req_f = 2'b11;
    req_h = 2'b11;
    build_seq();
    // R1: outputs low during reset even with requests high and a live strobe
    for (int i = 0; i < 3; i++) begin
      @(posedge clk_full);
      #2;
      chk("R1 reset en full", en_f, 1'b0);
      chk("R1 reset en half", en_h, 1'b0);
      chk("R1 reset gated full", gated_f, 1'b0);
      chk("R1 reset gated half", gated_h, 1'b0);
    end
    // Release at a falling edge so that the next rising edge is a clk_half rise
    do @(negedge clk_full); while (clk_half !== 1'b0);
    rst_n = 1'b1;
    fork
      drive_all();
      monitor_all();
    join
    chk("R8 postamble glitch edges", n_glitch, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(WD_CYCLES * 8);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule